// File: doc/BRIEF.md
# LIN Slave Break and Sync Timer

This block sits beside a UART on the receive side of a LIN slave node. It watches the received line and does two timing jobs. A slow break timer measures how long the line stays low. When that low time reaches a programmed limit, the block reports that a break field has been seen. A fast counter then measures the synchronisation byte (0x55). It counts clock cycles between two programmable falling edges of that byte. Software reads the count after the stop edge and derives the bit time, and so the baud rate, for bus rates between 1 kBaud and 20 kBaud.

There are four event flags: break seen, sync count started, sync count stopped and break timer overflow. Each flag is sticky and is cleared by writing a one to it. The four flags are ORed into a single interrupt request. The received line is first passed through a two-flop synchroniser. The synchronised line feeds the edge detectors and also a gated copy that goes on to the UART.

Both timers run in one clock domain. The break timer advances on a tick that a divider derives from the main clock while the line is low. The divide ratio is chosen so that the tick approximates a slow low-power oscillator: for example, a 5 MHz clock divided by 38 gives a tick of about 131 kHz.

Top module: `lin_sync_timer`

## Requirements
- R1: The line input passes through a two-flop synchroniser. A change on `rxd_in` first shows on `rxd_to_uart` after the second rising clock edge, and all edge detection uses this synchronised line.
- R2: While `rx_enable` is 0, `rxd_to_uart` is held at 1. While it is 1, `rxd_to_uart` follows the synchronised line.
- R3: The synchronised line may stay low for L cycles. The break timer then reaches floor(L/BRK_DIV) ticks. Flag bit 0 (break seen) is set when the tick count reaches `brk_limit` (1 or more) while the line is low.
- R4: The break timer returns to zero whenever the line is high, so each low period is judged on its own. Two short low pulses separated by one high cycle never add up to a break.
- R5: Flag bit 4 (break error) is set when the line is still low on the tick after the break timer has reached its maximum value 2^BRK_W-1. This is the case when floor(L/BRK_DIV) >= 2^BRK_W. The timer holds at its maximum value and does not wrap.
- R6: A detected break arms the sync counter while `sync_enable` is 1. Counting the falling edges after that break from 1, the edge numbered `start_edge` (1 to 5) sets flag bit 1 (sync started) and restarts `sync_count` from 0.
- R7: The falling edge numbered `stop_edge` (greater than `start_edge`, at most 5) sets flag bit 2 (sync stopped). `sync_count` then holds the number of clock cycles between the start and stop falling edges until the next start edge. With a bit time of T cycles, the sync byte spans 2*T*(stop_edge-start_edge) cycles.
- R8: `sync_count` saturates at 2^SYNC_W-1 instead of wrapping.
- R9: A write strobe `flag_clr_wr` clears every flag whose bit in `flag_clr_mask` is 1. Mask bits that are 0 leave their flags unchanged. Bit 3 always reads 0.
- R10: `irq` is 1 exactly when at least one flag bit is set.
- R11: While `sync_enable` is 0, no falling edge sets flag bit 1 or bit 2. Break detection still works.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock for both timers |
| rst_n | input | 1 | Active-low asynchronous reset |
| rxd_in | input | 1 | Received LIN line, asynchronous |
| rx_enable | input | 1 | Gate for the UART receive path |
| sync_enable | input | 1 | Enables sync-byte measurement |
| start_edge | input | 3 | Falling-edge number that starts the sync count |
| stop_edge | input | 3 | Falling-edge number that stops the sync count |
| brk_limit | input | BRK_W | Break threshold in break-timer ticks |
| flag_clr_wr | input | 1 | Write strobe for clearing flags |
| flag_clr_mask | input | 5 | Write-one-to-clear mask for the flags |
| flags | output | 5 | Bit 0 break seen, 1 sync started, 2 sync stopped, 3 zero, 4 break error |
| sync_count | output | SYNC_W | Measured sync span in clock cycles |
| irq | output | 1 | OR of all flags |
| rxd_to_uart | output | 1 | Gated synchronised line for the UART |

## Verification
A break timer that fails to restart would show as a break flag after a run of short pulses. The flag would appear a few cycles after the total low time crossed the limit. A tick count that is off by one would move the break threshold by exactly BRK_DIV cycles of low time, and a sweep of the low length through that point shows it. An edge index that is out of step, or a counter that starts or stops one cycle late, would change `sync_count`, visible as soon as the stop flag rises. A counter that wraps would give a small count in place of the saturated value.

// File: rtl/lin_pkg.sv
package lin_pkg;
   localparam int FLAG_W   = 5;
   localparam int EDGE_W   = 3;
   localparam int F_BREAK  = 0;
   localparam int F_START  = 1;
   localparam int F_STOP   = 2;
   localparam int F_BRKERR = 4;
   localparam logic [FLAG_W-1:0] FLAG_USED = 5'b10111;

   typedef enum logic [1:0] {
      SY_IDLE  = 2'd0,
      SY_ARMED = 2'd1,
      SY_COUNT = 2'd2,
      SY_DONE  = 2'd3
   } sync_state_e;
endpackage

// File: rtl/lin_rx_sync.sv
module lin_rx_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rxd_i,
   output logic line_o,
   output logic fall_o,
   output logic rise_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("lin_rx_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] shreg;
   logic              line_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg  <= '1;
         line_q <= 1'b1;
      end else begin
         shreg  <= {shreg[STAGES-2:0], rxd_i};
         line_q <= shreg[STAGES-1];
      end
   end

   assign line_o = shreg[STAGES-1];
   assign fall_o = line_q & ~line_o;
   assign rise_o = ~line_q & line_o;

   // R1: a falling edge is reported only when the line was high one cycle earlier
   p_fall_after_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
      fall_o |-> $past(line_o));
endmodule

// File: rtl/lin_break_timer.sv
module lin_break_timer #(
   parameter int CNT_W = 12,
   parameter int DIV   = 38
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             line_i,
   input  logic             rise_i,
   input  logic [CNT_W-1:0] limit_i,
   output logic             brk_evt_o,
   output logic             err_evt_o
);
   if (CNT_W < 2) begin : g_bad_w
      $error("lin_break_timer: CNT_W must be at least 2");
   end
   if (DIV < 1) begin : g_bad_div
      $error("lin_break_timer: DIV must be at least 1");
   end

   localparam logic [CNT_W-1:0] CMAX = '1;
   localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

   logic             tick;
   logic [CNT_W-1:0] cnt;

   if (DIV == 1) begin : g_nodiv
      assign tick = ~line_i;
   end else begin : g_div
      localparam int DIV_W = $clog2(DIV);
      localparam logic [DIV_W-1:0] DLAST = DIV_W'(DIV - 1);
      logic [DIV_W-1:0] div_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)               div_q <= '0;
         else if (line_i)          div_q <= '0;
         else if (div_q == DLAST)  div_q <= '0;
         else                      div_q <= div_q + DIV_W'(1);
      end
      assign tick = ~line_i && (div_q == DLAST);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     cnt <= '0;
      else if (line_i)                cnt <= '0;
      else if (tick && cnt != CMAX)   cnt <= cnt + ONE;
   end

   assign brk_evt_o = tick && (cnt != CMAX) && ((cnt + ONE) == limit_i);
   assign err_evt_o = tick && (cnt == CMAX);

   // R4: timer restarts after a rising edge
   p_restart_on_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
      rise_i |=> (cnt == '0));
   // R5: timer never wraps from its maximum while the line stays low
   p_no_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt == CMAX && !line_i) |=> (cnt == CMAX));
endmodule

// File: rtl/lin_sync_counter.sv
module lin_sync_counter
   import lin_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en_i,
   input  logic              brk_evt_i,
   input  logic              fall_i,
   input  logic [EDGE_W-1:0] start_idx_i,
   input  logic [EDGE_W-1:0] stop_idx_i,
   output logic              start_evt_o,
   output logic              stop_evt_o,
   output logic [CNT_W-1:0]  cnt_o
);
   localparam logic [CNT_W-1:0]  CMAX   = '1;
   localparam logic [EDGE_W-1:0] IDXMAX = '1;

   sync_state_e       state;
   logic [EDGE_W-1:0] idx;
   logic [EDGE_W-1:0] nxt_idx;
   logic [CNT_W-1:0]  cnt;

   always_comb begin
      nxt_idx     = (idx == IDXMAX) ? idx : idx + EDGE_W'(1);
      start_evt_o = en_i && !brk_evt_i && fall_i && (state == SY_ARMED) &&
                    (nxt_idx == start_idx_i);
      stop_evt_o  = en_i && !brk_evt_i && fall_i && (state == SY_COUNT) &&
                    (nxt_idx == stop_idx_i);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= SY_IDLE;
         idx   <= '0;
      end else if (!en_i) begin
         state <= SY_IDLE;
         idx   <= '0;
      end else if (brk_evt_i) begin
         state <= SY_ARMED;
         idx   <= '0;
      end else begin
         if (fall_i && (state == SY_ARMED || state == SY_COUNT)) idx <= nxt_idx;
         if (start_evt_o)     state <= SY_COUNT;
         else if (stop_evt_o) state <= SY_DONE;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                cnt <= '0;
      else if (start_evt_o)                      cnt <= '0;
      else if (state == SY_COUNT && cnt != CMAX) cnt <= cnt + CNT_W'(1);
   end

   assign cnt_o = cnt;

   // R7: measured value is held once counting has stopped
   p_hold_after_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (state == SY_DONE && !start_evt_o) |=> $stable(cnt));
   // R8: the count saturates instead of wrapping
   p_saturate_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt == CMAX && !start_evt_o) |=> (cnt == CMAX));
   // R11: no start or stop event while disabled
   p_quiet_when_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !en_i |-> !(start_evt_o || stop_evt_o));
endmodule

// File: rtl/lin_flags.sv
module lin_flags
   import lin_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [FLAG_W-1:0] set_i,
   input  logic              clr_wr_i,
   input  logic [FLAG_W-1:0] clr_mask_i,
   output logic [FLAG_W-1:0] flags_o,
   output logic              irq_o
);
   logic [FLAG_W-1:0] flags_q;
   logic [FLAG_W-1:0] clr_eff;

   assign clr_eff = clr_wr_i ? clr_mask_i : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags_q <= '0;
      else        flags_q <= ((flags_q & ~clr_eff) | set_i) & FLAG_USED;
   end

   assign flags_o = flags_q;
   assign irq_o   = |flags_q;

   // R9: flags only rise on a set event
   p_rise_needs_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (set_i == '0) |=> ((flags_q & ~$past(flags_q)) == '0));
   // R9: a write-one-to-clear without a set empties the selected bits
   p_clear_works_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_wr_i && set_i == '0) |=> ((flags_q & $past(clr_mask_i)) == '0));
endmodule

// File: rtl/lin_sync_timer.sv
module lin_sync_timer
   import lin_pkg::*;
#(
   parameter int SYNC_W  = 16,
   parameter int BRK_W   = 12,
   parameter int BRK_DIV = 38,
   parameter int STAGES  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rxd_in,
   input  logic              rx_enable,
   input  logic              sync_enable,
   input  logic [EDGE_W-1:0] start_edge,
   input  logic [EDGE_W-1:0] stop_edge,
   input  logic [BRK_W-1:0]  brk_limit,
   input  logic              flag_clr_wr,
   input  logic [FLAG_W-1:0] flag_clr_mask,
   output logic [FLAG_W-1:0] flags,
   output logic [SYNC_W-1:0] sync_count,
   output logic              irq,
   output logic              rxd_to_uart
);
   if (SYNC_W < 8 || SYNC_W > 32) begin : g_bad_sync_w
      $error("lin_sync_timer: SYNC_W must lie in 8..32");
   end

   logic line, fall, rise;
   logic brk_evt, err_evt, start_evt, stop_evt;
   logic [FLAG_W-1:0] set_vec;

   lin_rx_sync #(.STAGES(STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .rxd_i(rxd_in),
      .line_o(line), .fall_o(fall), .rise_o(rise));

   lin_break_timer #(.CNT_W(BRK_W), .DIV(BRK_DIV)) u_brk (
      .clk(clk), .rst_n(rst_n), .line_i(line), .rise_i(rise),
      .limit_i(brk_limit), .brk_evt_o(brk_evt), .err_evt_o(err_evt));

   lin_sync_counter #(.CNT_W(SYNC_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .en_i(sync_enable), .brk_evt_i(brk_evt),
      .fall_i(fall), .start_idx_i(start_edge), .stop_idx_i(stop_edge),
      .start_evt_o(start_evt), .stop_evt_o(stop_evt), .cnt_o(sync_count));

   always_comb begin
      set_vec           = '0;
      set_vec[F_BREAK]  = brk_evt;
      set_vec[F_START]  = start_evt;
      set_vec[F_STOP]   = stop_evt;
      set_vec[F_BRKERR] = err_evt;
   end

   lin_flags u_flags (
      .clk(clk), .rst_n(rst_n), .set_i(set_vec), .clr_wr_i(flag_clr_wr),
      .clr_mask_i(flag_clr_mask), .flags_o(flags), .irq_o(irq));

   assign rxd_to_uart = rx_enable ? line : 1'b1;

   // R10: the interrupt rises only together with a new flag
   p_irq_follows_flags_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> ($past(set_vec) != '0));
endmodule

// File: tb/sim_lin_sync_timer.sv
`timescale 1ns/1ps
module sim_lin_sync_timer;
   localparam int SW = 10, BW = 6, DV = 4;
   localparam int SMAX = (1 << SW) - 1;
   localparam int BMAXT = 1 << BW;

   logic clk = 0, rst_n = 0;
   logic rxd_in = 1, rx_enable = 1, sync_enable = 0, flag_clr_wr = 0;
   logic [2:0] start_edge = 3'd1, stop_edge = 3'd5;
   logic [BW-1:0] brk_limit = 6'd5;
   logic [4:0] flag_clr_mask = 0;
   logic [4:0] flags;
   logic [SW-1:0] sync_count;
   logic irq, rxd_to_uart;
   int checks = 0, errors = 0;
   bit done = 0;

   always #4 clk = ~clk;

   lin_sync_timer #(.SYNC_W(SW), .BRK_W(BW), .BRK_DIV(DV), .STAGES(2)) u0 (
      .clk(clk), .rst_n(rst_n), .rxd_in(rxd_in), .rx_enable(rx_enable),
      .sync_enable(sync_enable), .start_edge(start_edge), .stop_edge(stop_edge),
      .brk_limit(brk_limit), .flag_clr_wr(flag_clr_wr), .flag_clr_mask(flag_clr_mask),
      .flags(flags), .sync_count(sync_count), .irq(irq), .rxd_to_uart(rxd_to_uart));

   task automatic check(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic cyc(int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic clear_all();
      flag_clr_mask = 5'h1f; flag_clr_wr = 1; cyc(1);
      flag_clr_wr = 0; flag_clr_mask = 0; cyc(1);
   endtask

   task automatic low_pulse(int n);
      rxd_in = 0; cyc(n); rxd_in = 1;
   endtask

   task automatic send_sync_byte(int t);
      for (int b = 0; b < 10; b++) begin
         rxd_in = (b == 0) ? 1'b0 : (b == 9) ? 1'b1 : ((b % 2) == 1);
         cyc(t);
      end
      rxd_in = 1;
   endtask

   task automatic run_sync(int s, int e, int t, int brk_len, bit en);
      int exp;
      clear_all();
      sync_enable = en; start_edge = 3'(s); stop_edge = 3'(e);
      low_pulse(brk_len); cyc(2 * t);
      send_sync_byte(t); cyc(6);
      exp = (e - s) * 2 * t;
      if (exp > SMAX) exp = SMAX;
      if (en) begin
         check("R6 start flag", int'(flags[1]), 1);
         check("R7 stop flag", int'(flags[2]), 1);
         if (exp == SMAX) check("R8 saturated count", int'(sync_count), exp);
         else             check("R7 sync span", int'(sync_count), exp);
      end else begin
         check("R11 start flag off", int'(flags[1]), 0);
         check("R11 stop flag off", int'(flags[2]), 0);
         check("R11 break still seen", int'(flags[0]), 1);
      end
   endtask

   initial begin
      cyc(3); rst_n = 1; cyc(2);
      check("R10 reset irq", int'(irq), 0);
      check("R9 reset flags", int'(flags), 0);
      check("R7 reset count", int'(sync_count), 0);
      check("R2 reset line", int'(rxd_to_uart), 1);

      // R1: two-cycle latency to the UART path
      rxd_in = 0; cyc(1);
      check("R1 after one edge", int'(rxd_to_uart), 1);
      cyc(1);
      check("R1 after two edges", int'(rxd_to_uart), 0);
      rx_enable = 0; #1;
      check("R2 gated high", int'(rxd_to_uart), 1);
      rxd_in = 1; cyc(4); rx_enable = 1; #1;
      check("R2 follows line", int'(rxd_to_uart), 1);

      // R3: break threshold sweep
      brk_limit = 6'd5;
      for (int len = 1; len <= 30; len++) begin
         clear_all(); low_pulse(len); cyc(5);
         check($sformatf("R3 break len %0d", len), int'(flags[0]), ((len / DV) >= 5) ? 1 : 0);
         check($sformatf("R5 no error len %0d", len), int'(flags[4]), 0);
      end

      // R5: overflow sweep
      for (int len = 250; len <= 260; len++) begin
         clear_all(); low_pulse(len); cyc(5);
         check($sformatf("R5 error len %0d", len), int'(flags[4]), ((len / DV) >= BMAXT) ? 1 : 0);
         check($sformatf("R3 break long %0d", len), int'(flags[0]), 1);
         check("R9 bit3 zero", int'(flags[3]), 0);
      end

      // R9: mask zero does nothing, partial clear
      flag_clr_mask = 5'h00; flag_clr_wr = 1; cyc(1); flag_clr_wr = 0; cyc(1);
      check("R9 zero mask keeps", int'(flags), 5'b10001);
      flag_clr_mask = 5'h01; flag_clr_wr = 1; cyc(1); flag_clr_wr = 0; cyc(1);
      check("R9 partial clear", int'(flags), 5'b10000);
      check("R10 irq with one flag", int'(irq), 1);
      clear_all();
      check("R10 irq cleared", int'(irq), 0);

      // R4: two short pulses never add up
      clear_all();
      low_pulse(5 * DV - 2); cyc(1); low_pulse(5 * DV - 2); cyc(6);
      check("R4 split pulses", int'(flags[0]), 0);

      // R6/R7: edge selection sweep
      for (int t = 3; t <= 5; t += 2)
         for (int s = 1; s <= 4; s++)
            for (int e = s + 1; e <= 5; e++)
               run_sync(s, e, t, 5 * DV + 3, 1'b1);

      run_sync(1, 5, 4, 5 * DV + 3, 1'b0);

      // R8: saturation with a slow byte
      brk_limit = 6'd63;
      run_sync(1, 5, 200, 254, 1'b1);

      done = 1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(8 * 200000);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule